// File: doc/BRIEF.md
# SIMD Bitwise Logic and Select Unit

This unit executes the three-register bitwise group of a vector instruction set on 128-bit operands. It takes a 32-bit instruction word and three operand vectors: the first source, the second source and the current contents of the destination. It returns the result vector one clock later, together with a valid flag and an unsupported flag. Register-file access, enable checks and exception handling stay with the surrounding pipeline. Register numbers in the instruction word are carried only for decoding and have no effect on the datapath.

The group has eight operations. There are four two-input forms: AND, AND with the complemented second source, OR, and OR with the complemented second source. There is an exclusive-or form. There are three bitwise-select forms that also take the old destination as a third operand. All three select forms share one select formula, y = a ^ ((a ^ first) & mask), and differ only in which operand acts as the base `a` and which acts as the mask. Bit 30 of the instruction chooses between full 128-bit width and 64-bit width. In 64-bit width the upper half of the result is forced to zero.

Top module: `simd_logic_unit`

## Requirements
- R1: After reset `out_valid`, `out_unsup` and `out_result` are all zero.
- R2: `out_valid` in a cycle equals `in_valid` of the previous cycle (one register stage).
- R3: Operation code {instr[29], instr[23:22]} = 000 gives first & second. Code 001 gives first & ~second.
- R4: Code 010 gives first | second. Code 011 gives first | ~second.
- R5: Code 100 gives first ^ second.
- R6: Code 101 takes each bit from first where the old destination bit is 1, and from second where it is 0.
- R7: Code 110 takes each bit from first where the second-source bit is 1, and keeps the old destination bit where it is 0.
- R8: Code 111 takes each bit from first where the second-source bit is 0, and keeps the old destination bit where it is 1.
- R9: With instr[30] = 0, result bits 127:64 are zero whatever the operands are, including a nonzero old destination. With instr[30] = 1, all 128 bits are produced.
- R10: The register fields instr[20:16], instr[9:5] and instr[4:0] do not affect the result.
- R11: An accepted word fails to match the group if instr[31] != 0, instr[28:24] != 01110, instr[21] != 1 or instr[15:10] != 000111. Such a word sets `out_unsup` with a zero result. Matching words clear `out_unsup`.
- R12: While `in_valid` is low, `out_result` holds its last value and `out_unsup` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| src_first | input | VEC_W | First source vector |
| src_second | input | VEC_W | Second source vector |
| dst_old | input | VEC_W | Current destination vector |
| out_valid | output | 1 | Result register holds a new result |
| out_unsup | output | 1 | Accepted word is outside the group |
| out_result | output | VEC_W | Result vector |

## Verification
The bench builds the unit with its defaults: VEC_W = 128 and LANE_W = 16. This gives eight generated lanes, so the 64-bit boundary falls between lane 3 and lane 4. Each of the eight operation codes is run at both widths. The operands are byte-repeated 00, 7F, 80 and FF patterns plus random vectors, and the bench's own per-bit select model sets the expected results. Upper-half clearing is checked with an all-ones old destination. The unsupported path is checked by flipping each fixed field.

// File: rtl/simd_logic_pkg.sv
package simd_logic_pkg;
  // Operation code is {instr[29], instr[23:22]}
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_ANDN = 3'b001,
    OP_OR   = 3'b010,
    OP_ORN  = 3'b011,
    OP_XOR  = 3'b100,
    OP_SELD = 3'b101,
    OP_INST = 3'b110,
    OP_INSF = 3'b111
  } logic_op_t;

  localparam logic [31:0] GROUP_MASK  = 32'h9F20_FC00;
  localparam logic [31:0] GROUP_MATCH = 32'h0E20_1C00;
endpackage

// File: rtl/simd_logic_decode.sv
module simd_logic_decode
  import simd_logic_pkg::*;
(
  input  logic [31:0] instr,
  output logic_op_t   op,
  output logic        wide,
  output logic        bad
);
  always_comb begin
    op   = logic_op_t'({instr[29], instr[23:22]});
    wide = instr[30];
    bad  = ((instr & GROUP_MASK) != GROUP_MATCH);
  end
endmodule

// File: rtl/simd_logic_lane.sv
module simd_logic_lane
  import simd_logic_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic_op_t         op,
  input  logic              kill,
  input  logic [LANE_W-1:0] first,
  input  logic [LANE_W-1:0] second,
  input  logic [LANE_W-1:0] dst,
  output logic [LANE_W-1:0] y
);
  logic [LANE_W-1:0] base;
  logic [LANE_W-1:0] mask;
  logic [LANE_W-1:0] sel;
  logic [LANE_W-1:0] raw;

  // Shared select: base ^ ((base ^ first) & mask)
  always_comb begin
    base = dst;
    mask = second;
    unique case (op)
      OP_SELD: begin base = second; mask = dst;     end
      OP_INST: begin base = dst;    mask = second;  end
      OP_INSF: begin base = dst;    mask = ~second; end
      default: begin base = dst;    mask = second;  end
    endcase
    sel = base ^ ((base ^ first) & mask);
  end

  always_comb begin
    unique case (op)
      OP_AND:  raw = first & second;
      OP_ANDN: raw = first & ~second;
      OP_OR:   raw = first | second;
      OP_ORN:  raw = first | ~second;
      OP_XOR:  raw = first ^ second;
      default: raw = sel;
    endcase
    y = kill ? '0 : raw;
  end
endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit
  import simd_logic_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      instr,
  input  logic [VEC_W-1:0] src_first,
  input  logic [VEC_W-1:0] src_second,
  input  logic [VEC_W-1:0] dst_old,
  output logic             out_valid,
  output logic             out_unsup,
  output logic [VEC_W-1:0] out_result
);
  localparam int NUM_LANES    = VEC_W / LANE_W;
  localparam int NARROW_LANES = NUM_LANES / 2;

  logic_op_t        op;
  logic             wide;
  logic             bad;
  logic [VEC_W-1:0] calc;

  simd_logic_decode u_dec (
    .instr (instr),
    .op    (op),
    .wide  (wide),
    .bad   (bad)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic kill;
    if (g >= NARROW_LANES) begin : g_upper
      assign kill = bad | ~wide;
    end else begin : g_lower
      assign kill = bad;
    end
    simd_logic_lane #(.LANE_W(LANE_W)) u_lane (
      .op     (op),
      .kill   (kill),
      .first  (src_first[g*LANE_W +: LANE_W]),
      .second (src_second[g*LANE_W +: LANE_W]),
      .dst    (dst_old[g*LANE_W +: LANE_W]),
      .y      (calc[g*LANE_W +: LANE_W])
    );
  end

  logic             valid_q, valid_d;
  logic             unsup_q, unsup_d;
  logic [VEC_W-1:0] result_q, result_d;

  always_comb begin
    valid_d  = in_valid;
    unsup_d  = in_valid & bad;
    result_d = in_valid ? calc : result_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      unsup_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q  <= valid_d;
      unsup_q  <= unsup_d;
      result_q <= result_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_unsup  = unsup_q;
  assign out_result = result_q;
endmodule

// File: rtl/simd_logic_unit_chk.sv
module simd_logic_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      instr,
  input logic             out_valid,
  input logic             out_unsup,
  input logic [VEC_W-1:0] out_result
);
  localparam int HALF = VEC_W / 2;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R12
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  // R11
  unsup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_unsup |-> (out_result == '0) && out_valid);
  // R9
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !instr[30]) |=> (out_result[VEC_W-1:HALF] == '0));
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!out_valid && !out_unsup);
    end
  end
endmodule

bind simd_logic_unit simd_logic_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .instr      (instr),
  .out_valid  (out_valid),
  .out_unsup  (out_unsup),
  .out_result (out_result)
);

// File: tb/simd_logic_unit_test.sv
module simd_logic_unit_test;
  localparam int W = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   instr = '0;
  logic [W-1:0]  src_first = '0;
  logic [W-1:0]  src_second = '0;
  logic [W-1:0]  dst_old = '0;
  logic          out_valid;
  logic          out_unsup;
  logic [W-1:0]  out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_logic_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_first(src_first), .src_second(src_second), .dst_old(dst_old),
    .out_valid(out_valid), .out_unsup(out_unsup), .out_result(out_result)
  );

  function automatic logic [31:0] mk(logic [2:0] op, logic q,
                                     logic [4:0] rm, logic [4:0] rn, logic [4:0] rd);
    return {1'b0, q, op[2], 5'b01110, op[1:0], 1'b1, rm, 6'b000111, rn, rd};
  endfunction

  function automatic logic [W-1:0] model(logic [31:0] ins, logic [W-1:0] a,
                                         logic [W-1:0] b, logic [W-1:0] d);
    logic [W-1:0] r;
    case ({ins[29], ins[23:22]})
      3'd0: r = a & b;
      3'd1: r = a & ~b;
      3'd2: r = a | b;
      3'd3: r = a | ~b;
      3'd4: r = a ^ b;
      3'd5: r = (d & a) | (~d & b);
      3'd6: r = (b & a) | (~b & d);
      default: r = (~b & a) | (b & d);
    endcase
    if (!ins[30]) r[W-1:64] = '0;
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one instruction; return after results are registered (at a negedge)
  task automatic issue(logic [31:0] ins, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; src_first = a; src_second = b; dst_old = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(logic [2:0] op, logic q, logic [W-1:0] a,
                        logic [W-1:0] b, logic [W-1:0] d);
    logic [31:0] ins;
    ins = mk(op, q, 5'd2, 5'd1, 5'd0);
    issue(ins, a, b, d);
    check(tag_of(op), out_result, model(ins, a, b, d));
    check("R2 valid", {127'd0, out_valid}, 128'd1);
    check("R11 unsup clear", {127'd0, out_unsup}, 128'd0);
    if (!q) check("R9 upper zero", {64'd0, out_result[W-1:64]}, '0);
  endtask

  task automatic t_reset();
    check("R1 valid", {127'd0, out_valid}, '0);
    check("R1 unsup", {127'd0, out_unsup}, '0);
    check("R1 result", out_result, '0);
  endtask

  task automatic t_patterns();
    logic [W-1:0] pat [4];
    pat[0] = {16{8'h00}}; pat[1] = {16{8'h7F}};
    pat[2] = {16{8'h80}}; pat[3] = {16{8'hFF}};
    for (int op = 0; op < 8; op++)
      for (int q = 0; q < 2; q++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            run_op(3'(op), q[0], pat[i], pat[j], pat[(i + j + 1) % 4]);
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++)
      for (int op = 0; op < 8; op++)
        run_op(3'(op), n[0], rnd(), rnd(), rnd());
  endtask

  task automatic t_narrow();
    // R9: all-ones old destination must not leak into the upper half
    for (int op = 0; op < 8; op++) begin
      issue(mk(3'(op), 1'b0, 5'd3, 5'd4, 5'd5), rnd(), rnd(), '1);
      check("R9 upper cleared", {64'd0, out_result[W-1:64]}, '0);
    end
  endtask

  task automatic t_fields();
    logic [W-1:0] a, b, d;
    a = rnd(); b = rnd(); d = rnd();
    for (int k = 0; k < 6; k++) begin
      logic [31:0] ins;
      ins = mk(3'd6, 1'b1, 5'($urandom), 5'($urandom), 5'($urandom));
      issue(ins, a, b, d);
      check("R10 fields", out_result, (b & a) | (~b & d));
    end
  endtask

  task automatic t_unsup();
    logic [31:0] good;
    int bits [6] = '{31, 28, 24, 21, 12, 15};
    good = mk(3'd2, 1'b1, 5'd1, 5'd2, 5'd3);
    foreach (bits[k]) begin
      issue(good ^ (32'd1 << bits[k]), '1, '1, '1);
      check("R11 unsup flag", {127'd0, out_unsup}, 128'd1);
      check("R11 zero result", out_result, '0);
    end
    issue(good, '1, '0, '0);
    check("R11 match clears", {127'd0, out_unsup}, '0);
  endtask

  task automatic t_hold();
    logic [W-1:0] a, b, held;
    a = rnd(); b = rnd();
    issue(mk(3'd4, 1'b1, 5'd0, 5'd0, 5'd0), a, b, '0);
    held = a ^ b;
    check("R5 xor", out_result, held);
    instr = 32'hFFFF_FFFF; src_first = rnd(); src_second = rnd(); dst_old = rnd();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R12 held", out_result, held);
      check("R2 idle", {126'd0, out_valid, out_unsup}, '0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_random();
    t_narrow();
    t_fields();
    t_unsup();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule